// File: doc/BRIEF.md
# Interrupt Controller Programming Interface

This block is the register front end of an eight-line interrupt controller. A host reaches it through two byte-wide addresses, selected by one address bit, with separate write and read strobes. Writes are decoded into an initialisation sequence, read and poll control words, and priority commands. The resulting state is exported to the controller's priority and request logic. That state covers the line mask, the vector base and the mode flags, together with single-cycle command strobes.

Request capture and priority evaluation stay outside the block. The priority logic feeds back the pending and in-service registers, the highest qualifying line, and its interrupt request. The block returns these on reads, gates the request while initialisation is in progress, and forms the acknowledge vector from the programmed base.

Top module: `pic_prog_if`

## Requirements
- R1: After reset the mask, vector base and all mode flags (nested mode, automatic end, special mask, read-select, poll) are 0, and the sequencer is idle, so `int_o` follows `req_i`.
- R2: A write at address 0 with data bit 4 set starts initialisation. In that cycle `clear_o` is 1. From the next cycle the mask, base and all mode flags are 0, and data bit 0 records whether a fourth word follows.
- R3: `int_o` is 0 in the cycle of an initialisation write and in every cycle until the sequence returns to idle.
- R4: A write at address 0 with bit 4 clear and bit 3 set is a control word. Bit 2 set arms a poll. Bit 1 set loads read-select from bit 0. Bit 6 set loads special mask from bit 5. A flag whose enable bit is clear keeps its value.
- R5: A write at address 0 with bits 4 and 3 clear pulses `cmd_valid_o` in that cycle, with `cmd_code_o` = data bits 7:5 and `cmd_level_o` = data bits 2:0. No other write pulses `cmd_valid_o`.
- R6: A write at address 1 while idle loads the mask from the data byte.
- R7: While initialising, the first write at address 1 loads the vector base from data bits 7:3. The second write goes to a fourth-word step if one was requested, and otherwise returns to idle. Neither write changes the mask.
- R8: A write at address 1 in the fourth-word step sets nested mode from bit 4 and automatic end from bit 1, then returns to idle.
- R9: With a poll armed, a read at either address with a qualifying line returns that line number. In the same cycle it pulses `poll_ack_o` with `poll_line_o` equal to the line, and it disarms the poll for the following cycles.
- R10: With a poll armed and no qualifying line, a read returns 7, gives no `poll_ack_o`, and disarms the poll.
- R11: Without a poll, a read at address 0 returns the in-service register when read-select is 1 and the pending register otherwise. A read at address 1 returns the mask.
- R12: `vector_o` is the base in bits 7:3 with the acknowledged line number in bits 2:0.
- R13: Data bits 3 and 1 of the initialisation word are ignored. The sequence takes the same steps as for the word with those bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 1 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| pend_i | input | 8 | Pending register from request logic |
| insvc_i | input | 8 | In-service register from priority logic |
| top_valid_i | input | 1 | A line qualifies for service |
| top_line_i | input | 3 | Highest qualifying line |
| req_i | input | 1 | Interrupt request from priority logic |
| ack_line_i | input | 3 | Line being acknowledged |
| int_o | output | 1 | Interrupt output to the processor |
| vector_o | output | 8 | Acknowledge vector |
| mask_o | output | 8 | Line mask |
| nested_o | output | 1 | Special nested mode |
| auto_end_o | output | 1 | Automatic end-of-interrupt mode |
| smask_o | output | 1 | Special mask mode |
| rdsel_o | output | 1 | Read-select: 1 returns in-service |
| poll_o | output | 1 | Poll armed |
| clear_o | output | 1 | Clear pending and in-service state |
| cmd_valid_o | output | 1 | Priority command strobe |
| cmd_code_o | output | 3 | Priority command code |
| cmd_level_o | output | 3 | Priority command level |
| poll_ack_o | output | 1 | Poll acknowledge strobe |
| poll_line_o | output | 3 | Line cleared by a poll |

## Verification
A sequencer stuck in a wrong step appears one write later. A stuck sequencer keeps `int_o` low, or it lets a base or mode word land in the mask, which the next mask read shows. A poll flag that does not disarm shows on the very next read, which returns a line number instead of a register. A wrong read-select or special-mask bit shows at the next status read or in the exported flag in the cycle after the control word.

// File: rtl/pic_prog_pkg.sv
package pic_prog_pkg;
    localparam int LINES = 8;
    localparam int LW    = $clog2(LINES);
    localparam int DW    = 8;
    localparam int BW    = DW - LW;

    // control-word bit positions (decoded by neighbours and host software)
    localparam int B_INIT  = 4;
    localparam int B_CTL   = 3;
    localparam int B_POLL  = 2;
    localparam int B_RSEN  = 1;
    localparam int B_RSV   = 0;
    localparam int B_SMEN  = 6;
    localparam int B_SMV   = 5;
    localparam int B_NEED4 = 0;
    localparam int B_NEST  = 4;
    localparam int B_AEND  = 1;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_BASE = 2'd1,
        SQ_W3   = 2'd2,
        SQ_W4   = 2'd3
    } seq_e;

    typedef struct packed {
        logic init;
        logic ctl;
        logic prio;
        logic port1;
    } wdec_t;

    typedef struct packed {
        logic nested;
        logic auto_end;
        logic smask;
        logic rdsel;
        logic poll;
    } mode_t;

    function automatic logic [DW-1:0] spurious_line();
        return DW'(LINES - 1);
    endfunction
endpackage

// File: rtl/pic_wr_decode.sv
module pic_wr_decode
    import pic_prog_pkg::*;
(
    input  logic          wr_i,
    input  logic          addr_i,
    input  logic [DW-1:0] wdata_i,
    output wdec_t         dec_o
);
    always_comb begin
        dec_o       = '0;
        if (wr_i) begin
            if (addr_i) begin
                dec_o.port1 = 1'b1;
            end else if (wdata_i[B_INIT]) begin
                dec_o.init  = 1'b1;
            end else if (wdata_i[B_CTL]) begin
                dec_o.ctl   = 1'b1;
            end else begin
                dec_o.prio  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_prog_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  wdec_t         dec_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          rd_i,
    output logic [DW-1:0] mask_o,
    output logic [BW-1:0] base_o,
    output mode_t         mode_o,
    output logic          idle_o
);
    seq_e seq_q;
    logic need4_q;

    assign idle_o = (seq_q == SQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst || dec_i.init) begin
            mask_o  <= '0;
            base_o  <= '0;
            mode_o  <= '0;
            need4_q <= rst ? 1'b0 : wdata_i[B_NEED4];
            seq_q   <= rst ? SQ_IDLE : SQ_BASE;
        end else begin
            if (rd_i && mode_o.poll)
                mode_o.poll <= 1'b0;
            if (dec_i.ctl) begin
                if (wdata_i[B_POLL])
                    mode_o.poll <= 1'b1;
                if (wdata_i[B_RSEN])
                    mode_o.rdsel <= wdata_i[B_RSV];
                if (wdata_i[B_SMEN])
                    mode_o.smask <= wdata_i[B_SMV];
            end
            if (dec_i.port1) begin
                unique case (seq_q)
                    SQ_IDLE: mask_o <= wdata_i;
                    SQ_BASE: begin
                        base_o <= wdata_i[DW-1:LW];
                        seq_q  <= SQ_W3;
                    end
                    SQ_W3: seq_q <= need4_q ? SQ_W4 : SQ_IDLE;
                    SQ_W4: begin
                        mode_o.nested   <= wdata_i[B_NEST];
                        mode_o.auto_end <= wdata_i[B_AEND];
                        seq_q           <= SQ_IDLE;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/pic_rd_mux.sv
module pic_rd_mux
    import pic_prog_pkg::*;
(
    input  logic          rd_i,
    input  logic          addr_i,
    input  mode_t         mode_i,
    input  logic [DW-1:0] mask_i,
    input  logic [DW-1:0] pend_i,
    input  logic [DW-1:0] insvc_i,
    input  logic          top_valid_i,
    input  logic [LW-1:0] top_line_i,
    output logic [DW-1:0] rdata_o,
    output logic          poll_ack_o,
    output logic [LW-1:0] poll_line_o
);
    always_comb begin
        if (mode_i.poll)
            rdata_o = top_valid_i ? DW'(top_line_i) : spurious_line();
        else if (addr_i)
            rdata_o = mask_i;
        else
            rdata_o = mode_i.rdsel ? insvc_i : pend_i;
    end

    assign poll_ack_o  = rd_i && mode_i.poll && top_valid_i;
    assign poll_line_o = top_line_i;
endmodule

// File: rtl/pic_prog_if.sv
module pic_prog_if
    import pic_prog_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          addr_i,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    input  logic [DW-1:0] pend_i,
    input  logic [DW-1:0] insvc_i,
    input  logic          top_valid_i,
    input  logic [LW-1:0] top_line_i,
    input  logic          req_i,
    input  logic [LW-1:0] ack_line_i,
    output logic          int_o,
    output logic [DW-1:0] vector_o,
    output logic [DW-1:0] mask_o,
    output logic          nested_o,
    output logic          auto_end_o,
    output logic          smask_o,
    output logic          rdsel_o,
    output logic          poll_o,
    output logic          clear_o,
    output logic          cmd_valid_o,
    output logic [2:0]    cmd_code_o,
    output logic [2:0]    cmd_level_o,
    output logic          poll_ack_o,
    output logic [LW-1:0] poll_line_o
);
    wdec_t         dec;
    mode_t         mode;
    logic [BW-1:0] base;
    logic          seq_idle;

    pic_wr_decode u_dec (
        .wr_i    (wr_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .dec_o   (dec)
    );

    pic_init_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .dec_i   (dec),
        .wdata_i (wdata_i),
        .rd_i    (rd_i),
        .mask_o  (mask_o),
        .base_o  (base),
        .mode_o  (mode),
        .idle_o  (seq_idle)
    );

    pic_rd_mux u_rd (
        .rd_i        (rd_i),
        .addr_i      (addr_i),
        .mode_i      (mode),
        .mask_i      (mask_o),
        .pend_i      (pend_i),
        .insvc_i     (insvc_i),
        .top_valid_i (top_valid_i),
        .top_line_i  (top_line_i),
        .rdata_o     (rdata_o),
        .poll_ack_o  (poll_ack_o),
        .poll_line_o (poll_line_o)
    );

    assign int_o       = req_i && seq_idle && !dec.init;
    assign clear_o     = dec.init;
    assign cmd_valid_o = dec.prio;
    assign cmd_code_o  = wdata_i[7:5];
    assign cmd_level_o = wdata_i[2:0];
    assign vector_o    = {base, ack_line_i};
    assign nested_o    = mode.nested;
    assign auto_end_o  = mode.auto_end;
    assign smask_o     = mode.smask;
    assign rdsel_o     = mode.rdsel;
    assign poll_o      = mode.poll;
endmodule

// File: rtl/pic_prog_if_chk.sv
module pic_prog_if_chk
    import pic_prog_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          addr_i,
    input logic          wr_i,
    input logic          rd_i,
    input logic [DW-1:0] wdata_i,
    input logic [DW-1:0] rdata_o,
    input logic          top_valid_i,
    input logic          int_o,
    input logic [DW-1:0] mask_o,
    input logic          nested_o,
    input logic          auto_end_o,
    input logic          smask_o,
    input logic          rdsel_o,
    input logic          poll_o,
    input logic          poll_ack_o,
    input logic          seq_idle
);
    // R2
    init_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !addr_i && wdata_i[B_INIT]) |=>
        (mask_o == '0 && !nested_o && !auto_end_o && !smask_o && !rdsel_o && !poll_o));

    // R3
    init_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !addr_i && wdata_i[B_INIT]) |=> !int_o);

    // R6
    mask_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && addr_i && seq_idle) |=> (mask_o == $past(wdata_i)));

    // R7
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && addr_i && !seq_idle) |=> $stable(mask_o));

    // R9
    poll_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_i && poll_o && !wr_i) |=> !poll_o);

    // R10
    poll_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_i && poll_o && !top_valid_i) |-> (rdata_o == spurious_line() && !poll_ack_o));
endmodule

bind pic_prog_if pic_prog_if_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .addr_i      (addr_i),
    .wr_i        (wr_i),
    .rd_i        (rd_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .top_valid_i (top_valid_i),
    .int_o       (int_o),
    .mask_o      (mask_o),
    .nested_o    (nested_o),
    .auto_end_o  (auto_end_o),
    .smask_o     (smask_o),
    .rdsel_o     (rdsel_o),
    .poll_o      (poll_o),
    .poll_ack_o  (poll_ack_o),
    .seq_idle    (seq_idle)
);

// File: tb/tb_pic_prog_if.sv
module tb_pic_prog_if;
    logic       clk = 1'b0;
    logic       rst;
    logic       addr_i, wr_i, rd_i;
    logic [7:0] wdata_i, pend_i, insvc_i;
    logic       top_valid_i, req_i;
    logic [2:0] top_line_i, ack_line_i;
    logic [7:0] rdata_o, vector_o, mask_o;
    logic       int_o, nested_o, auto_end_o, smask_o, rdsel_o, poll_o, clear_o;
    logic       cmd_valid_o, poll_ack_o;
    logic [2:0] cmd_code_o, cmd_level_o, poll_line_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pic_prog_if dut (.*);

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(logic a, logic [7:0] d);
        @(negedge clk);
        rd_i = 1'b0; addr_i = a; wdata_i = d; wr_i = 1'b1;
        #1;
    endtask

    task automatic get(logic a);
        @(negedge clk);
        wr_i = 1'b0; addr_i = a; rd_i = 1'b1;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        wr_i = 1'b0; rd_i = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        chk("R1 mask", mask_o, 0);
        chk("R1 flags", {nested_o, auto_end_o, smask_o, rdsel_o, poll_o}, 0);
        chk("R1 int follows req", int_o, 1);
        ack_line_i = 3'd5;
        #1;
        chk("R12 vector base 0", vector_o, 8'h05);
    endtask

    task automatic t_init4();
        put(1'b0, 8'h11);
        chk("R2 clear strobe", clear_o, 1);
        chk("R3 int low in init cycle", int_o, 0);
        chk("R5 no cmd on init", cmd_valid_o, 0);
        put(1'b1, 8'h48);
        chk("R3 int low while busy", int_o, 0);
        put(1'b1, 8'h00);
        put(1'b1, 8'h12);
        chk("R3 int low in step 4", int_o, 0);
        idle();
        chk("R8 nested", nested_o, 1);
        chk("R8 auto end", auto_end_o, 1);
        chk("R7 mask untouched", mask_o, 0);
        chk("R3 int back", int_o, 1);
        ack_line_i = 3'd3;
        #1;
        chk("R12 vector", vector_o, 8'h4B);
    endtask

    task automatic t_init3();
        put(1'b1, 8'hF0);
        idle();
        chk("R6 mask load", mask_o, 8'hF0);
        put(1'b0, 8'h1A);
        idle();
        chk("R2 mask cleared", mask_o, 0);
        chk("R2 modes cleared", {nested_o, auto_end_o}, 0);
        put(1'b1, 8'h20);
        put(1'b1, 8'hFF);
        idle();
        chk("R13 idle after third word", int_o, 1);
        chk("R7 mask held", mask_o, 0);
        ack_line_i = 3'd0;
        #1;
        chk("R7 base", vector_o, 8'h20);
        put(1'b1, 8'h5A);
        idle();
        chk("R6 mask after seq", mask_o, 8'h5A);
        get(1'b1);
        chk("R11 read mask", rdata_o, 8'h5A);
    endtask

    task automatic t_ctl();
        pend_i = 8'h81; insvc_i = 8'h24;
        put(1'b0, 8'h0B);
        chk("R5 no cmd on ctl", cmd_valid_o, 0);
        idle();
        chk("R4 rdsel set", rdsel_o, 1);
        get(1'b0);
        chk("R11 read insvc", rdata_o, 8'h24);
        put(1'b0, 8'h68);
        idle();
        chk("R4 smask set", smask_o, 1);
        chk("R4 rdsel kept", rdsel_o, 1);
        put(1'b0, 8'h0A);
        idle();
        chk("R4 rdsel clear", rdsel_o, 0);
        chk("R4 smask kept", smask_o, 1);
        get(1'b0);
        chk("R11 read pend", rdata_o, 8'h81);
        put(1'b0, 8'h48);
        idle();
        chk("R4 smask clear", smask_o, 0);
    endtask

    task automatic t_cmd();
        put(1'b0, 8'hA3);
        chk("R5 cmd valid", cmd_valid_o, 1);
        chk("R5 cmd code", cmd_code_o, 5);
        chk("R5 cmd level", cmd_level_o, 3);
        put(1'b1, 8'h5A);
        chk("R5 no cmd on port1", cmd_valid_o, 0);
        idle();
    endtask

    task automatic t_poll();
        put(1'b0, 8'h0C);
        idle();
        chk("R4 poll armed", poll_o, 1);
        top_valid_i = 1'b1; top_line_i = 3'd6;
        get(1'b1);
        chk("R9 poll data", rdata_o, 6);
        chk("R9 poll ack", poll_ack_o, 1);
        chk("R9 poll line", poll_line_o, 6);
        idle();
        chk("R9 disarmed", poll_o, 0);
        chk("R9 no ack after", poll_ack_o, 0);
        get(1'b0);
        chk("R9 normal read after", rdata_o, 8'h81);
        put(1'b0, 8'h0C);
        top_valid_i = 1'b0;
        get(1'b0);
        chk("R10 empty poll data", rdata_o, 7);
        chk("R10 no ack", poll_ack_o, 0);
        idle();
        chk("R10 disarmed", poll_o, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; addr_i = 1'b0; wr_i = 1'b0; rd_i = 1'b0; wdata_i = '0;
        pend_i = '0; insvc_i = '0; top_valid_i = 1'b0; top_line_i = '0;
        req_i = 1'b1; ack_line_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle();
        t_reset();
        t_init4();
        t_init3();
        t_ctl();
        t_cmd();
        t_poll();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule